// File: doc/BRIEF.md
# Packed Palette Color Table

This block holds the color lookup table of a display pipeline. Software programs it through a register window of 32-bit words. Each word packs two 16-bit color entries, so the window's words fill all the table entries. The block keeps every raw word as written, so the register side can read it back unchanged.

On every write the block also decodes the two packed entries into full 24-bit RGB values. It stores them in an expanded table, and that table serves a pixel-side lookup port.

The scan-out logic presents an 8-bit pixel index and receives the expanded color one cycle later. A register write and a pixel lookup may happen in the same cycle. The lookup then returns the table contents as they stood before the write.

Top module: `palx_top`

## Requirements
- R1: After reset every raw word reads 0 and every expanded entry returns 0.
- R2: Writing word n updates entry 2n from bits 15:0 and entry 2n+1 from bits 31:16.
- R3: Within a 16-bit entry, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. The pixel output carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: Each 5-bit component is widened to 8 bits by a left shift of 3, so bits 2:0 of every output channel are zero.
- R5: Bit 15 of each entry (word bits 15 and 31) has no effect on the expanded color.
- R6: A register read of word n returns, one cycle after the index is presented, the full 32-bit value last written to it, including bits 15 and 31.
- R7: The pixel port returns the color of the index presented one cycle earlier, and a new index may be presented every cycle.
- R8: A lookup, or a register read, of an entry or word in the cycle it is written returns the old value. The new value is returned from the following cycle on.
- R9: A write to word n changes no entry other than 2n and 2n+1, and no other raw word.
- R10: While the write enable is low, the write index and data have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 7 | Word index to write |
| cfg_wr_data | input | 32 | Packed pair of 16-bit entries |
| cfg_rd_idx | input | 7 | Word index to read back |
| cfg_rd_data | output | 32 | Raw word, one cycle after cfg_rd_idx |
| pix_idx | input | 8 | Pixel color index |
| pix_rgb | output | 24 | Expanded color {R,G,B}, one cycle after pix_idx |

## Verification
The bench programs words whose two halves differ in every field. A design that swaps the halves or mislabels a component therefore returns a wrong color at an exact index. It sets bit 15 of both entries and compares the colors with those of the same entry with the bit clear. A design that leaks the intensity bit into blue, or drops it from the raw read-back, shows a mismatch. Same-cycle write and lookup of one entry is checked for the old value and then for the new one, which catches a write-through or a write that lands a cycle late. A toggling write index and data with the strobe low, and the neighbours of each written pair, expose stray or misdecoded writes.

// File: rtl/palx_pkg.sv
package palx_pkg;
    localparam int CH_IN_W      = 5;
    localparam int CH_OUT_W     = 8;
    localparam int ENTRY_W      = 16;
    localparam int PER_WORD     = 2;
    localparam int WORD_W       = ENTRY_W * PER_WORD;
    localparam int RGB_W        = 3 * CH_OUT_W;
    localparam int WIDEN_SHIFT  = CH_OUT_W - CH_IN_W;

    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [RGB_W-1:0]   rgb_t;

    // Widen one packed entry to 24-bit color; bit 15 (intensity) unused.
    function automatic rgb_t widen_entry(input entry_t e);
        logic [CH_OUT_W-1:0] red, grn, blu;
        red = {e[0 +: CH_IN_W],           {WIDEN_SHIFT{1'b0}}};
        grn = {e[CH_IN_W +: CH_IN_W],     {WIDEN_SHIFT{1'b0}}};
        blu = {e[2*CH_IN_W +: CH_IN_W],   {WIDEN_SHIFT{1'b0}}};
        return {red, grn, blu};
    endfunction
endpackage

// File: rtl/palx_raw_store.sv
module palx_raw_store #(
    parameter int NUM_WORDS = 128,
    parameter int WORD_W    = 32,
    localparam int AW       = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] words;
        logic [WORD_W-1:0]                rd;
    } raw_st_t;

    raw_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.rd = st_q.words[rd_idx];
        if (wr_en) begin
            st_d.words[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;

    // R6: a written word is held exactly as given
    a_r6_raw_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.words[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/palx_entry_decode.sv
module palx_entry_decode
    import palx_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output rgb_t              rgb_o [PER_WORD]
);
    for (genvar h = 0; h < PER_WORD; h++) begin : g_half
        always_comb begin
            rgb_o[h] = widen_entry(word_i[h*ENTRY_W +: ENTRY_W]);
        end
    end
endmodule

// File: rtl/palx_color_store.sv
module palx_color_store
    import palx_pkg::*;
#(
    parameter int NUM_ENTRIES = 256,
    localparam int IW         = $clog2(NUM_ENTRIES),
    localparam int PW         = IW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] wr_pair,
    input  rgb_t          wr_lo,
    input  rgb_t          wr_hi,
    input  logic [IW-1:0] rd_idx,
    output rgb_t          rd_rgb
);
    typedef struct packed {
        logic [NUM_ENTRIES-1:0][RGB_W-1:0] tbl;
        rgb_t                              out;
    } col_st_t;

    col_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.out = st_q.tbl[rd_idx];
        if (we) begin
            st_d.tbl[{wr_pair, 1'b0}] = wr_lo;
            st_d.tbl[{wr_pair, 1'b1}] = wr_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_rgb = st_q.out;

    // R2: even entry takes the low half
    a_r2_even_slot: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> st_q.tbl[{$past(wr_pair), 1'b0}] == $past(wr_lo));
    // R2: odd entry takes the high half
    a_r2_odd_slot: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> st_q.tbl[{$past(wr_pair), 1'b1}] == $past(wr_hi));
    // R4: low three bits of each channel stay zero
    a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rgb[2:0] == 3'b0) && (rd_rgb[10:8] == 3'b0) && (rd_rgb[18:16] == 3'b0));
endmodule

// File: rtl/palx_top.sv
module palx_top
    import palx_pkg::*;
#(
    parameter int NUM_WORDS    = 128,
    localparam int NUM_ENTRIES = NUM_WORDS * PER_WORD,
    localparam int WAW         = $clog2(NUM_WORDS),
    localparam int PAW         = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [WAW-1:0]    cfg_wr_idx,
    input  logic [WORD_W-1:0] cfg_wr_data,
    input  logic [WAW-1:0]    cfg_rd_idx,
    output logic [WORD_W-1:0] cfg_rd_data,
    input  logic [PAW-1:0]    pix_idx,
    output logic [RGB_W-1:0]  pix_rgb
);
    rgb_t pair_rgb [PER_WORD];
    rgb_t pix_rgb_w;

    palx_raw_store #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .rd_idx  (cfg_rd_idx),
        .rd_data (cfg_rd_data)
    );

    palx_entry_decode u_dec (
        .word_i (cfg_wr_data),
        .rgb_o  (pair_rgb)
    );

    palx_color_store #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_wr_en),
        .wr_pair (cfg_wr_idx),
        .wr_lo   (pair_rgb[0]),
        .wr_hi   (pair_rgb[1]),
        .rd_idx  (pix_idx),
        .rd_rgb  (pix_rgb_w)
    );

    assign pix_rgb = pix_rgb_w;
endmodule

// File: tb/palx_top_tb.sv
module palx_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [6:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [6:0]  cfg_rd_idx = '0;
    logic [31:0] cfg_rd_data;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [128];

    always #2 clk = ~clk;

    palx_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    function automatic logic [23:0] exp_rgb(input logic [15:0] e);
        return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
    endfunction

    function automatic logic [23:0] exp_entry(input int n);
        logic [31:0] w;
        w = model[n / 2];
        return (n % 2 == 1) ? exp_rgb(w[31:16]) : exp_rgb(w[15:0]);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr_word(input int idx, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_wr_idx = idx[6:0]; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model[idx] = d;
    endtask

    task automatic rd_pix(input int idx, output logic [23:0] v);
        pix_idx = idx[7:0];
        @(negedge clk);
        v = pix_rgb;
    endtask

    task automatic rd_raw(input int idx, output logic [31:0] v);
        cfg_rd_idx = idx[6:0];
        @(negedge clk);
        v = cfg_rd_data;
    endtask

    task automatic t_reset();
        logic [23:0] p; logic [31:0] r;
        rd_raw(0, r);   check("R1 raw word 0", r, 0);
        rd_raw(127, r); check("R1 raw word 127", r, 0);
        rd_pix(0, p);   check("R1 entry 0", {8'h0, p}, 0);
        rd_pix(255, p); check("R1 entry 255", {8'h0, p}, 0);
    endtask

    task automatic t_pair();
        logic [23:0] p;
        wr_word(5, {16'h7C00, 16'h001F});
        rd_pix(10, p); check("R2 R3 entry 10 red", {8'h0, p}, 32'h00F80000);
        rd_pix(11, p); check("R2 R3 entry 11 blue", {8'h0, p}, 32'h000000F8);
        wr_word(6, {16'h03E0, 16'h4201});
        rd_pix(13, p); check("R3 entry 13 green", {8'h0, p}, 32'h0000F800);
        rd_pix(12, p); check("R4 entry 12 widen", {8'h0, p}, {8'h0, exp_rgb(16'h4201)});
        rd_pix(10, p); check("R9 entry 10 kept", {8'h0, p}, 32'h00F80000);
        rd_pix(14, p); check("R9 entry 14 untouched", {8'h0, p}, 0);
    endtask

    task automatic t_intensity();
        logic [23:0] p; logic [31:0] r;
        wr_word(9, {16'h8000 | 16'h2A55, 16'h8000 | 16'h1234});
        rd_pix(18, p); check("R5 entry 18 bit15 ignored", {8'h0, p}, {8'h0, exp_rgb(16'h1234)});
        rd_pix(19, p); check("R5 entry 19 bit15 ignored", {8'h0, p}, {8'h0, exp_rgb(16'h2A55)});
        rd_raw(9, r);  check("R6 raw keeps bit15/31", r, 32'hAA55_9234);
    endtask

    task automatic t_latency();
        logic [23:0] p;
        pix_idx = 8'd10;
        @(negedge clk);
        check("R7 back-to-back 10", {8'h0, pix_rgb}, {8'h0, exp_entry(10)});
        pix_idx = 8'd11;
        @(negedge clk);
        check("R7 back-to-back 11", {8'h0, pix_rgb}, {8'h0, exp_entry(11)});
        pix_idx = 8'd12;
        @(negedge clk);
        check("R7 back-to-back 12", {8'h0, pix_rgb}, {8'h0, exp_entry(12)});
        rd_pix(19, p);
        check("R7 after gap 19", {8'h0, p}, {8'h0, exp_entry(19)});
    endtask

    task automatic t_same_cycle();
        logic [23:0] old_p; logic [31:0] old_r;
        wr_word(20, 32'h1111_2222);
        old_p = exp_entry(40); old_r = model[20];
        cfg_wr_en = 1'b1; cfg_wr_idx = 7'd20; cfg_wr_data = 32'h0C63_7FFF;
        pix_idx = 8'd40; cfg_rd_idx = 7'd20;
        @(negedge clk);
        cfg_wr_en = 1'b0; model[20] = 32'h0C63_7FFF;
        check("R8 same-cycle pixel old", {8'h0, pix_rgb}, {8'h0, old_p});
        check("R8 same-cycle raw old", cfg_rd_data, old_r);
        @(negedge clk);
        check("R8 next pixel new", {8'h0, pix_rgb}, {8'h0, exp_entry(40)});
        check("R8 next raw new", cfg_rd_data, 32'h0C63_7FFF);
    endtask

    task automatic t_no_write();
        logic [23:0] p; logic [31:0] r;
        for (int i = 0; i < 8; i++) begin
            cfg_wr_en = 1'b0; cfg_wr_idx = 7'(20 + i); cfg_wr_data = 32'hFFFF_FFFF;
            @(negedge clk);
        end
        rd_raw(20, r); check("R10 raw 20 unchanged", r, model[20]);
        rd_raw(21, r); check("R10 raw 21 unchanged", r, 0);
        rd_pix(41, p); check("R10 entry 41 unchanged", {8'h0, p}, {8'h0, exp_entry(41)});
        rd_pix(43, p); check("R10 entry 43 unchanged", {8'h0, p}, 0);
    endtask

    task automatic t_sweep();
        logic [23:0] p; logic [31:0] r;
        for (int i = 0; i < 128; i++) begin
            wr_word(i, {16'(i * 16'h1357 ^ 16'hA5A5), 16'(i * 16'h0F1D + 16'h0101)});
        end
        for (int i = 0; i < 128; i++) begin
            rd_raw(i, r); check("R6 sweep raw", r, model[i]);
        end
        for (int n = 0; n < 256; n++) begin
            rd_pix(n, p); check("R2 sweep entry", {8'h0, p}, {8'h0, exp_entry(n)});
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pair();
        t_intensity();
        t_latency();
        t_same_cycle();
        t_no_write();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule